// File: doc/BRIEF.md
# Two-Frame Transmit Elastic Store

This block carries a serial PCM stream from the system-bus clock domain to the transmit line clock domain. It stores the stream in a 64-byte memory that is split into two frame halves of 32 time slots each. On the bus side, each serial bit is captured on a selectable edge of the bus clock. Bits are packed MSB first into bytes, and each byte is written at the byte offset equal to its time slot. On the line side, the bytes are read back bit by bit on the line clock. The only value that crosses from the write side to the read side is a Gray-coded write position.

A 2-bit mode input chooses how the read position is kept clear of the write position:
- **Two-frame normal:** whole-frame slips with a wide margin.
- **Two-frame short:** whole-frame slips with a narrow margin, for lower latency.
- **64-bit elastic:** a bit-granular window that is re-centred when it is exhausted.
- **Bypass:** the input bit is retimed straight onto the line clock.

A processor port in the bus clock domain can read and write any byte in every mode. A serial byte write in the same cycle takes priority, and the processor access is then delayed by one cycle.

Top module: `tx_elastic_store`

## Requirements
- R1: While rst_ni is low, line_data_o, line_fsync_o, slip_o, slip_dir_o and cpu_ack_o are all 0.
- R2: bus_fsync_o is high while the next captured bus bit is the MSB of time slot 0. Each group of 8 captured bits, MSB first, is written to byte offset n of the current frame half, where n is its slot. Offsets 0..31 form the low half and 32..63 form the high half.
- R3: line_fsync_o is high in the same line cycle as the MSB of slot 0. line_data_o then carries slots 0..31 in order, each MSB first, each taken from its own slot offset.
- R4: fall_edge_i=0 samples bus_data_i on the rising bus clock edge. fall_edge_i=1 samples it on the falling edge.
- R5: mode_i=00 (normal) checks the write-to-read separation only at read frame starts, where slip_o coincides with line_fsync_o. If the separation is below 64 bits, the read position jumps back one frame (repeat, slip_dir_o=0). If it is above 448 bits, the read position jumps forward one frame (drop, slip_dir_o=1).
- R6: mode_i=10 (short) follows the R5 rule with a threshold of 16 bits and a restart separation of 64 bits.
- R7: mode_i=01 (elastic) re-centres the read position 32 bits behind the write position when the separation reaches 0 (slip_dir_o=0) or reaches 64 or more (slip_dir_o=1). This check is made on every line cycle.
- R8: mode_i=11 (bypass) has three effects. line_data_o equals bus_data_i sampled at the previous rising line edge. slip_o stays 0. The serial path does not write the memory.
- R9: A processor access in the bus clock domain has the following timing:
  - cpu_ack_o pulses one bus cycle after cpu_req_i is sampled.
  - If a serial byte write falls in that same cycle, the acknowledge comes one cycle later.
  - cpu_rdata_o holds the addressed byte while cpu_ack_o is high.
  - This timing applies in all modes.
- R10: bus_fsync_o repeats every 256 bus cycles. line_fsync_o repeats every 256 line cycles, except across a read-position reload or an elastic slip.
- R11: A mode change restarts the read position at the nominal separation of the new mode (normal 256, short 64, elastic 32 bits), without raising slip_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | System-bus clock |
| line_clk_i | input | 1 | Transmit line clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 normal, 01 elastic, 10 short, 11 bypass |
| fall_edge_i | input | 1 | Capture input on falling bus edge |
| bus_data_i | input | 1 | Serial PCM input |
| bus_fsync_o | output | 1 | Next captured bit is MSB of slot 0 |
| line_data_o | output | 1 | Serial PCM output |
| line_fsync_o | output | 1 | Output bit is MSB of slot 0 |
| slip_o | output | 1 | One-cycle slip pulse, line domain |
| slip_dir_o | output | 1 | Slip kind: 0 repeat, 1 drop |
| cpu_req_i | input | 1 | Processor access request (one cycle) |
| cpu_we_i | input | 1 | Processor write enable |
| cpu_addr_i | input | 6 | Processor byte address |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Processor read data, valid with ack |
| cpu_ack_o | output | 1 | Processor access done |

## Verification
The checker watches several properties on every cycle:
- processor acknowledge timing, with and without a colliding serial write;
- absence of slips in bypass;
- alignment of frame-mode slips with read frame starts;
- exact 256-cycle spacing of both frame markers.

The bench scenarios cover what a cycle-level property cannot see:
- the slot-to-offset mapping and bit order through the memory;
- the choice of capture edge;
- the persistence of processor writes while bypass is selected;
- the time each mode needs before it slips under a fixed clock-rate offset, which reveals its threshold and restart separation.

// File: rtl/tes_pkg.sv
package tes_pkg;
  typedef enum logic [1:0] {
    MODE_NORM  = 2'b00,
    MODE_ELAS  = 2'b01,
    MODE_SHORT = 2'b10,
    MODE_BYP   = 2'b11
  } mode_e;
endpackage

// File: rtl/tes_mem.sv
module tes_mem #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/tes_wr_side.sv
module tes_wr_side #(
  parameter int AW = 6,
  parameter int PW = AW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_edge_i,
  input  logic          data_i,
  input  logic          byp_i,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [7:0]    cpu_wdata_i,
  output logic [7:0]    cpu_rdata_o,
  output logic          cpu_ack_o,
  output logic          fsync_o,
  output logic [PW-1:0] wp_gray_o,
  output logic          ser_we_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [7:0]    mem_wdata_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [7:0]    mem_rdata_i
);
  logic          neg_q, bit_in;
  logic [PW-1:0] wp_q, wp_n;
  logic [6:0]    sr_q;
  logic          pend_q, pend_we_q;
  logic [AW-1:0] pend_addr_q;
  logic [7:0]    pend_wdata_q;
  logic          cur_req, cur_we, cpu_go;
  logic [AW-1:0] cur_addr;
  logic [7:0]    cur_wdata;

  // falling-edge capture, consumed at the following rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= data_i;
  end

  assign bit_in   = fall_edge_i ? neg_q : data_i;
  assign wp_n     = wp_q + 1'b1;
  assign ser_we_o = !byp_i && (wp_q[2:0] == 3'd7);
  assign fsync_o  = (wp_q[PW-2:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q      <= '0;
      sr_q      <= '0;
      wp_gray_o <= '0;
    end else begin
      wp_q      <= wp_n;
      sr_q      <= {sr_q[5:0], bit_in};
      wp_gray_o <= wp_n ^ (wp_n >> 1);
    end
  end

  // processor port: serial write wins, loser waits one cycle
  assign cur_req   = pend_q | cpu_req_i;
  assign cur_we    = pend_q ? pend_we_q    : cpu_we_i;
  assign cur_addr  = pend_q ? pend_addr_q  : cpu_addr_i;
  assign cur_wdata = pend_q ? pend_wdata_q : cpu_wdata_i;
  assign cpu_go    = cur_req && !ser_we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_we_q    <= 1'b0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      cpu_ack_o    <= 1'b0;
      cpu_rdata_o  <= '0;
    end else begin
      cpu_ack_o <= cpu_go;
      if (cpu_go) begin
        pend_q      <= 1'b0;
        cpu_rdata_o <= mem_rdata_i;
      end else if (cpu_req_i && !pend_q) begin
        pend_q       <= 1'b1;
        pend_we_q    <= cpu_we_i;
        pend_addr_q  <= cpu_addr_i;
        pend_wdata_q <= cpu_wdata_i;
      end
    end
  end

  assign mem_we_o    = ser_we_o | (cpu_go & cur_we);
  assign mem_waddr_o = ser_we_o ? wp_q[PW-1:3] : cur_addr;
  assign mem_wdata_o = ser_we_o ? {sr_q, bit_in} : cur_wdata;
  assign mem_raddr_o = cur_addr;
endmodule

// File: rtl/tes_rd_side.sv
module tes_rd_side
  import tes_pkg::*;
#(
  parameter int AW        = 6,
  parameter int PW        = AW + 3,
  parameter int FRAME     = 256,
  parameter int TH_NORM   = 64,
  parameter int TH_SHORT  = 16,
  parameter int NOM_NORM  = 256,
  parameter int NOM_SHORT = 64,
  parameter int NOM_ELAS  = 32,
  parameter int ELAS_WIN  = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_e         mode_i,
  input  logic [PW-1:0] wp_gray_i,
  input  logic          bus_data_i,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          data_o,
  output logic          fsync_o,
  output logic          slip_o,
  output logic          slip_dir_o,
  output logic          rp_load_o
);
  localparam logic [PW-1:0] FRAME_P = PW'(FRAME);
  localparam logic [PW-1:0] LO_N    = PW'(TH_NORM);
  localparam logic [PW-1:0] HI_N    = PW'(2 * FRAME - TH_NORM);
  localparam logic [PW-1:0] LO_S    = PW'(TH_SHORT);
  localparam logic [PW-1:0] HI_S    = PW'(2 * FRAME - TH_SHORT);
  localparam logic [PW-1:0] WIN_P   = PW'(ELAS_WIN);

  logic [PW-1:0] s1_q, s2_q, wp_l, rp_q, rp_n, sep, nom, lo_th, hi_th;
  logic [1:0]    init_q;
  mode_e         mode_q;
  logic          slip_n, dir_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= wp_gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign wp_l[i] = ^s2_q[PW-1:i];
  end

  always_comb begin
    unique case (mode_q)
      MODE_NORM:  nom = PW'(NOM_NORM);
      MODE_SHORT: nom = PW'(NOM_SHORT);
      MODE_ELAS:  nom = PW'(NOM_ELAS);
      default:    nom = '0;
    endcase
    lo_th = (mode_q == MODE_SHORT) ? LO_S : LO_N;
    hi_th = (mode_q == MODE_SHORT) ? HI_S : HI_N;
  end

  assign sep       = wp_l - rp_q;
  assign rp_load_o = (init_q == 2'd1);

  always_comb begin
    rp_n   = rp_q + 1'b1;
    slip_n = 1'b0;
    dir_n  = 1'b0;
    if (rp_load_o) begin
      rp_n = wp_l - nom;
    end else if (init_q == 2'd0) begin
      unique case (mode_q)
        MODE_NORM, MODE_SHORT: begin
          if (rp_q[PW-2:0] == '0) begin
            if (sep < lo_th) begin
              rp_n   = rp_q + 1'b1 + FRAME_P;
              slip_n = 1'b1;
            end else if (sep > hi_th) begin
              rp_n   = rp_q + 1'b1 + FRAME_P;
              slip_n = 1'b1;
              dir_n  = 1'b1;
            end
          end
        end
        MODE_ELAS: begin
          if (sep == '0 || sep >= WIN_P) begin
            rp_n   = wp_l - nom;
            slip_n = 1'b1;
            dir_n  = (sep != '0);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_NORM;
      init_q     <= 2'd3;
      rp_q       <= '0;
      data_o     <= 1'b0;
      fsync_o    <= 1'b0;
      slip_o     <= 1'b0;
      slip_dir_o <= 1'b0;
    end else begin
      mode_q     <= mode_i;
      init_q     <= (mode_i != mode_q) ? 2'd3 : ((init_q != 2'd0) ? init_q - 2'd1 : 2'd0);
      rp_q       <= rp_n;
      data_o     <= (mode_q == MODE_BYP) ? bus_data_i : mem_rdata_i[3'd7 - rp_q[2:0]];
      fsync_o    <= (rp_q[PW-2:0] == '0);
      slip_o     <= slip_n;
      slip_dir_o <= dir_n;
    end
  end

  assign mem_raddr_o = rp_q[PW-1:3];
endmodule

// File: rtl/tx_elastic_store.sv
module tx_elastic_store
  import tes_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int TH_NORM   = 64,
  parameter int TH_SHORT  = 16,
  parameter int NOM_SHORT = 64,
  parameter int NOM_ELAS  = 32,
  parameter int ELAS_WIN  = 64,
  localparam int AW       = $clog2(2 * SLOTS),
  localparam int PW       = AW + 3,
  localparam int FRAME    = SLOTS * 8
) (
  input  logic          bus_clk_i,
  input  logic          line_clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          fall_edge_i,
  input  logic          bus_data_i,
  output logic          bus_fsync_o,
  output logic          line_data_o,
  output logic          line_fsync_o,
  output logic          slip_o,
  output logic          slip_dir_o,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [7:0]    cpu_wdata_i,
  output logic [7:0]    cpu_rdata_o,
  output logic          cpu_ack_o
);
  logic          ser_we, rp_load, mem_we;
  logic [PW-1:0] wp_gray;
  logic [AW-1:0] mem_waddr, cpu_raddr, line_raddr;
  logic [7:0]    mem_wdata, cpu_rdata_m, line_rdata_m;
  mode_e         mode;

  assign mode = mode_e'(mode_i);

  tes_wr_side #(.AW(AW), .PW(PW)) u_wr (
    .clk_i       (bus_clk_i),
    .rst_ni      (rst_ni),
    .fall_edge_i (fall_edge_i),
    .data_i      (bus_data_i),
    .byp_i       (mode == MODE_BYP),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_rdata_o (cpu_rdata_o),
    .cpu_ack_o   (cpu_ack_o),
    .fsync_o     (bus_fsync_o),
    .wp_gray_o   (wp_gray),
    .ser_we_o    (ser_we),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata),
    .mem_raddr_o (cpu_raddr),
    .mem_rdata_i (cpu_rdata_m)
  );

  tes_mem #(.AW(AW), .DW(8)) u_mem (
    .wclk_i    (bus_clk_i),
    .we_i      (mem_we),
    .waddr_i   (mem_waddr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (cpu_raddr),
    .rdata_a_o (cpu_rdata_m),
    .raddr_b_i (line_raddr),
    .rdata_b_o (line_rdata_m)
  );

  tes_rd_side #(
    .AW(AW), .PW(PW), .FRAME(FRAME), .TH_NORM(TH_NORM), .TH_SHORT(TH_SHORT),
    .NOM_NORM(FRAME), .NOM_SHORT(NOM_SHORT), .NOM_ELAS(NOM_ELAS), .ELAS_WIN(ELAS_WIN)
  ) u_rd (
    .clk_i       (line_clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .wp_gray_i   (wp_gray),
    .bus_data_i  (bus_data_i),
    .mem_raddr_o (line_raddr),
    .mem_rdata_i (line_rdata_m),
    .data_o      (line_data_o),
    .fsync_o     (line_fsync_o),
    .slip_o      (slip_o),
    .slip_dir_o  (slip_dir_o),
    .rp_load_o   (rp_load)
  );
endmodule

// File: rtl/tes_chk.sv
module tes_chk (
  input logic       bus_clk_i,
  input logic       line_clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       cpu_req_i,
  input logic       cpu_ack_o,
  input logic       ser_we,
  input logic       bus_fsync_o,
  input logic       line_fsync_o,
  input logic       slip_o,
  input logic       rp_load
);
  logic [8:0] bcnt_q, lcnt_q;
  logic       bval_q, lval_q;

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      bval_q <= 1'b0;
    end else begin
      bcnt_q <= bus_fsync_o ? 9'd1 : bcnt_q + 9'd1;
      if (bus_fsync_o) bval_q <= 1'b1;
    end
  end

  always_ff @(posedge line_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcnt_q <= '0;
      lval_q <= 1'b0;
    end else begin
      lcnt_q <= line_fsync_o ? 9'd1 : lcnt_q + 9'd1;
      if (slip_o || rp_load) lval_q <= 1'b0;
      else if (line_fsync_o) lval_q <= 1'b1;
    end
  end

  a_r9_ack_next: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (cpu_req_i && !ser_we) |=> cpu_ack_o);

  a_r9_ack_held: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (cpu_req_i && ser_we) |=> !cpu_ack_o);

  a_r9_ack_late: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    $past(cpu_req_i && ser_we, 2) |-> cpu_ack_o);

  a_r8_byp_no_slip: assert property (@(posedge line_clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'b11) |-> !slip_o);

  a_r5_slip_at_frame: assert property (@(posedge line_clk_i) disable iff (!rst_ni)
    (slip_o && ($past(mode_i) == 2'b00 || $past(mode_i) == 2'b10)) |-> line_fsync_o);

  a_r10_bus_period: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (bus_fsync_o && bval_q) |-> (bcnt_q == 9'd256));

  a_r10_line_period: assert property (@(posedge line_clk_i) disable iff (!rst_ni)
    (line_fsync_o && lval_q && !slip_o && !rp_load) |-> (lcnt_q == 9'd256));
endmodule

bind tx_elastic_store tes_chk u_chk (
  .bus_clk_i    (bus_clk_i),
  .line_clk_i   (line_clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .cpu_req_i    (cpu_req_i),
  .cpu_ack_o    (cpu_ack_o),
  .ser_we       (ser_we),
  .bus_fsync_o  (bus_fsync_o),
  .line_fsync_o (line_fsync_o),
  .slip_o       (slip_o),
  .rp_load      (rp_load)
);

// File: tb/sim_tx_elastic_store.sv
`timescale 1ps/1ps
module sim_tx_elastic_store;
  localparam int CLK_PERIOD = 10000;

  int bus_half  = CLK_PERIOD / 2;
  int line_half = CLK_PERIOD / 2;
  int nchk = 0, nfail = 0;
  int seed = 0;

  logic bus_clk = 1'b0, line_clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic fall = 1'b0, drive_en = 1'b1, drv_bit = 1'b0, byp_bit = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic bus_data, bus_fsync, line_data, line_fsync, slip, slip_dir, cpu_ack;
  logic [7:0] cpu_rdata;

  assign bus_data = drive_en ? drv_bit : byp_bit;

  tx_elastic_store u0 (
    .bus_clk_i(bus_clk), .line_clk_i(line_clk), .rst_ni(rst_n), .mode_i(mode),
    .fall_edge_i(fall), .bus_data_i(bus_data), .bus_fsync_o(bus_fsync),
    .line_data_o(line_data), .line_fsync_o(line_fsync), .slip_o(slip),
    .slip_dir_o(slip_dir), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .cpu_ack_o(cpu_ack)
  );

  initial forever #(bus_half) bus_clk = ~bus_clk;
  initial begin
    #2500;
    forever #(line_half) line_clk = ~line_clk;
  end

  function automatic logic [7:0] pat(input int ts);
    return 8'((ts * 29 + seed) & 255);
  endfunction

  // serial source: bit for the coming active edge, realigned on bus_fsync
  initial begin
    int k = 0;
    forever begin
      if (fall) @(posedge bus_clk);
      else      @(negedge bus_clk);
      #1;
      if (bus_fsync) k = 0;
      drv_bit = pat(k / 8)[7 - (k % 8)];
      k = (k + 1) % 256;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_frame(input string tag);
    do @(negedge line_clk); while (!line_fsync);
    for (int ts = 0; ts < 32; ts++) begin
      logic [7:0] got = '0;
      for (int b = 0; b < 8; b++) begin
        got = {got[6:0], line_data};
        @(negedge line_clk);
      end
      check(tag, got, pat(ts));
    end
  endtask

  task automatic count_slips(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge line_clk);
      if (slip) n++;
    end
  endtask

  task automatic wait_slip(output int cyc, output logic dir, output logic fs);
    cyc = 0;
    do begin
      @(negedge line_clk);
      cyc++;
    end while (!slip && cyc < 20000);
    dir = slip_dir;
    fs  = line_fsync;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge line_clk);
    mode = m;
  endtask

  task automatic cpu_op(input logic we, input logic [5:0] a, input logic [7:0] d,
                        output int lat, output logic [7:0] rd);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge bus_clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_ack && lat < 5) begin
      @(negedge bus_clk);
      lat++;
    end
    rd = cpu_rdata;
  endtask

  task automatic wait_bus_fsync();
    do @(negedge bus_clk); while (!bus_fsync);
  endtask

  initial begin
    #(longint'(CLK_PERIOD) * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n, lat, cyc, t0;
    logic dir, fs;
    logic [7:0] rd;

    // R1: outputs quiet in reset
    repeat (3) @(negedge line_clk);
    check("R1 line_data", line_data, 0);
    check("R1 line_fsync", line_fsync, 0);
    check("R1 slip", slip, 0);
    check("R1 slip_dir", slip_dir, 0);
    check("R1 cpu_ack", cpu_ack, 0);
    @(negedge bus_clk);
    rst_n = 1'b1;

    // R2 R3: normal mode, rising capture
    seed = 11;
    count_slips(800, n);
    check("R11 no slip after start", n, 0);
    repeat (2) check_frame("R3 normal rising");

    // R10: marker spacing
    wait_bus_fsync();
    t0 = 0;
    do begin @(negedge bus_clk); t0++; end while (!bus_fsync);
    check("R10 bus_fsync period", t0, 256);
    do @(negedge line_clk); while (!line_fsync);
    t0 = 0;
    do begin @(negedge line_clk); t0++; end while (!line_fsync);
    check("R10 line_fsync period", t0, 256);

    // R4: falling-edge capture
    @(negedge bus_clk);
    fall = 1'b1;
    seed = 77;
    repeat (800) @(negedge line_clk);
    repeat (2) check_frame("R4 falling capture");
    @(negedge bus_clk);
    fall = 1'b0;

    // R6 R11: short mode data path
    seed = 140;
    set_mode(2'b10);
    count_slips(800, n);
    check("R11 no slip entering short", n, 0);
    check_frame("R6 short data");

    // R7 R11: elastic mode data path
    seed = 201;
    set_mode(2'b01);
    count_slips(800, n);
    check("R11 no slip entering elastic", n, 0);
    check_frame("R7 elastic data");

    // R2 R9: processor port
    wait_bus_fsync();
    cpu_op(1'b0, 6'd20, 8'h00, lat, rd);
    check("R9 latency free", lat, 1);
    check("R2 low half slot20", rd, pat(20));
    cpu_op(1'b0, 6'd52, 8'h00, lat, rd);
    check("R2 high half slot20", rd, pat(20));
    cpu_op(1'b1, 6'd24, 8'h5A, lat, rd);
    cpu_op(1'b0, 6'd24, 8'h00, lat, rd);
    check("R9 readback", rd, 8'h5A);
    wait_bus_fsync();
    repeat (7) @(negedge bus_clk);
    cpu_op(1'b0, 6'd29, 8'h00, lat, rd);
    check("R9 latency on conflict", lat, 2);
    check("R9 read on conflict", rd, pat(29));

    // R8: bypass
    drive_en = 1'b0;
    set_mode(2'b11);
    repeat (10) @(negedge line_clk);
    begin
      logic [15:0] lfsr = 16'hACE1;
      logic prev = 1'b0;
      int errs = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge line_clk);
        if (i > 0 && line_data != prev) errs++;
        if (slip) errs++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        byp_bit = lfsr[0];
        prev = lfsr[0];
      end
      check("R8 bypass passthrough", errs, 0);
    end
    wait_bus_fsync();
    repeat (7) @(negedge bus_clk);
    cpu_op(1'b1, 6'd5, 8'hC3, lat, rd);
    check("R8 R9 no conflict in bypass", lat, 1);
    repeat (600) @(negedge bus_clk);
    cpu_op(1'b0, 6'd5, 8'h00, lat, rd);
    check("R8 memory untouched", rd, 8'hC3);
    drive_en = 1'b1;

    // R7: elastic slips, line fast then slow
    line_half = 4900;
    set_mode(2'b01);
    wait_slip(cyc, dir, fs);
    check("R7 elastic repeat window", (cyc > 1200 && cyc < 2000), 1);
    check("R7 elastic repeat dir", dir, 0);
    set_mode(2'b11);
    repeat (8) @(negedge line_clk);
    line_half = 5100;
    set_mode(2'b01);
    wait_slip(cyc, dir, fs);
    check("R7 elastic drop window", (cyc > 1200 && cyc < 2000), 1);
    check("R7 elastic drop dir", dir, 1);

    // R6: short mode slip, line fast
    line_half = 4900;
    set_mode(2'b10);
    wait_slip(cyc, dir, fs);
    check("R6 short slip window", (cyc > 2000 && cyc < 3300), 1);
    check("R6 short slip dir", dir, 0);
    check("R6 slip on frame", fs, 1);

    // R5: normal mode slips
    set_mode(2'b00);
    wait_slip(cyc, dir, fs);
    check("R5 normal repeat window", (cyc > 9000 && cyc < 10600), 1);
    check("R5 normal repeat dir", dir, 0);
    check("R5 repeat on frame", fs, 1);
    line_half = 5100;
    wait_slip(cyc, dir, fs);
    check("R5 normal drop seen", (cyc < 20000), 1);
    check("R5 normal drop dir", dir, 1);
    check("R5 drop on frame", fs, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule